// File: doc/BRIEF.md
# FIFO-Paced Byte DMA Channel

This block is one DMA channel that copies a run of bytes from a source address to a destination address. It is paced by a peripheral FIFO. The FIFO raises a request line while it can take or supply a byte. For each byte the channel answers with a one-cycle acknowledge, at the moment it writes that byte to its destination.

Software uses a small register port. It loads the source pointer, the destination pointer, the byte total and a source-space select bit, and then sets the enable bit. While the channel is enabled, its configuration is frozen. When the last byte has moved, the channel clears its own enable bit. It reports the start and the end of the run as single-cycle event strobes for a separate interrupt unit to collect.

The memory side is a simple master port. It issues a read, takes the data one cycle later, and then issues a write. The source-space select bit is shown on a sideband line during reads, so the fabric can route the read to internal or external memory.

Top module: `fifo_byte_dma`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all four readback registers read zero, and mem_req, fifo_ack, start_evt and end_evt are low.
- R2: While the enable bit is clear, the channel makes no memory access and gives no fifo_ack, even when fifo_req is held high.
- R3: Each byte uses exactly one memory read, at the source pointer, followed two cycles later by one write of that data to the destination pointer. fifo_ack is high for exactly the cycle of that write. A new byte starts only when the channel is idle, enabled and sees fifo_req high. Bytes beyond the programmed total are never written.
- R4: After each byte, both the source pointer and the destination pointer have advanced by one. Register select 0 reads back the current source pointer and select 1 reads back the current destination pointer.
- R5: Control bit 1 is the source-space select. mem_ext equals this bit on every read cycle and is low on write cycles.
- R6: Register select encoding: 0 = source pointer, 1 = destination pointer, 2 = byte total, 3 = control (bit 0 enable, bit 1 source space). While the enable bit is set, writes to any select are ignored.
- R7: Setting the enable bit from 0 to 1 clears the byte counter. When the counter equals the byte total, the channel clears its enable bit and pulses end_evt in the same edge. Select 2 still reads the programmed total.
- R8: A byte total of zero ends the run one cycle after the start strobe, with no memory access and no fifo_ack.
- R9: start_evt is high for the one cycle after the clock edge that takes the enabling write. start_evt and end_evt are always single-cycle pulses, and each run gives exactly one of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for both write and readback |
| reg_wdata | input | REG_W (16) | Register write data |
| reg_rdata | output | REG_W (16) | Readback of the selected register |
| fifo_req | input | 1 | Peripheral FIFO can take or supply a byte |
| fifo_ack | output | 1 | One byte has been moved for the FIFO |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_ext | output | 1 | Source space of a read (1 = external) |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_wdata | output | DATA_W (8) | Write data |
| mem_rdata | input | DATA_W (8) | Read data, valid the cycle after a read |
| start_evt | output | 1 | Run-start strobe |
| end_evt | output | 1 | Run-end strobe |

## Verification
The hardest situation to reach is a rejected write while the channel sits enabled and stalled. The channel has to be enabled with fifo_req held low, so it cannot finish before the bench tries to overwrite pointers, total and control. The bench then reads every register back unchanged before it releases fifo_req. Random runs toggle fifo_req every cycle, so a request can drop or rise in the middle of a byte. These runs mix both source spaces and include totals of zero and one. Every destination byte, the guard byte past the end, and both final pointers are compared with values computed from the source patterns.

// File: rtl/dma_chan_pkg.sv
// Package: shared encodings for the byte DMA channel.
// Assumes: a two-bit register select and a four-state transfer sequence.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_EXT_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_LATCH = 2'd2,
        ST_WRITE = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: configuration registers of the channel.
// Holds the pointers, the byte total, the source-space bit and the enable bit.
// Assumes: writes are accepted only while disabled; step and finish come
// from the sequencer and occur only while enabled.
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  byte_total,
    output logic              ext_sel,
    output logic              chan_en,
    output logic              arm,
    output logic              start_evt
);

    logic cfg_open;

    // Configuration is writable only while the channel is idle-disabled.
    assign cfg_open = !chan_en;

    // Arm: a control write that raises the enable bit from 0.
    assign arm = wr_en && cfg_open && (wr_sel == SEL_CTL) && wr_data[CTL_EN_BIT];

    // Register update: software writes, pointer stepping and self-disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr    <= '0;
            dst_ptr    <= '0;
            byte_total <= '0;
            ext_sel    <= 1'b0;
            chan_en    <= 1'b0;
        end else begin
            if (wr_en && cfg_open) begin
                case (reg_sel_e'(wr_sel))
                    SEL_SRC: src_ptr    <= ADDR_W'(wr_data);
                    SEL_DST: dst_ptr    <= ADDR_W'(wr_data);
                    SEL_CNT: byte_total <= CNT_W'(wr_data);
                    default: begin
                        chan_en <= wr_data[CTL_EN_BIT];
                        ext_sel <= wr_data[CTL_EXT_BIT];
                    end
                endcase
            end else if (step) begin
                src_ptr <= src_ptr + 1'b1;
                dst_ptr <= dst_ptr + 1'b1;
            end
            if (finish) begin
                chan_en <= 1'b0;
            end
        end
    end

    // Start strobe: one cycle after the enabling write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) start_evt <= 1'b0;
        else        start_evt <= arm;
    end

    p_step_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (src_ptr == $past(src_ptr) + 1'b1) && (dst_ptr == $past(dst_ptr) + 1'b1));

    p_frozen_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(byte_total) && $stable(ext_sel));

    p_frozen_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !step) |=> $stable(src_ptr) && $stable(dst_ptr));

    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !chan_en);

    p_start_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> chan_en);

endmodule

// File: rtl/dma_byte_ctr.sv
// Module: byte counter of the channel.
// Counts the bytes moved in the current run and flags when the total is reached.
// Assumes: the total is stable while counting (it is frozen by the registers).
module dma_byte_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic             done
);

    logic [CNT_W-1:0] count;

    // Counter: cleared on arming, advanced once per moved byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count + 1'b1;
    end

    // Completion compare against the programmed total.
    assign done = (count == total);

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count < total));

endmodule

// File: rtl/dma_xfer_fsm.sv
// Module: transfer sequencer.
// Moves one byte per FIFO request: read, latch, write with acknowledge.
// Finishes the run when the counter reports done.
// Assumes: memory read data arrives exactly one cycle after a read request.
module dma_xfer_fsm
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              done,
    input  logic              fifo_req,
    input  logic              ext_sel,
    input  logic [ADDR_W-1:0] src_ptr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_ext,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fifo_ack,
    output logic              step,
    output logic              finish,
    output logic              end_evt
);

    xfer_state_e       state;
    logic [DATA_W-1:0] data_q;

    // Completion is taken in idle, before any new byte can start.
    assign finish = (state == ST_IDLE) && chan_en && done;

    // State sequence and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (chan_en && !done && fifo_req) state <= ST_READ;
                end
                ST_READ:  state <= ST_LATCH;
                ST_LATCH: begin
                    data_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // End strobe: registered from the completion condition.
    always_ff @(posedge clk) begin
        if (!rst_n) end_evt <= 1'b0;
        else        end_evt <= finish;
    end

    // Master port and handshake outputs decoded from the state.
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_ext   = (state == ST_READ) && ext_sel;
        mem_addr  = (state == ST_WRITE) ? dst_ptr : src_ptr;
        mem_wdata = data_q;
        fifo_ack  = (state == ST_WRITE);
        step      = (state == ST_WRITE);
    end

    p_bus_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> chan_en);

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req ##1 (mem_req && mem_we && fifo_ack));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ack |=> !fifo_ack);

    p_end_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |-> !chan_en);

    p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> !end_evt);

endmodule

// File: rtl/fifo_byte_dma.sv
// Module: top of the FIFO-paced byte DMA channel.
// Joins the registers, the byte counter and the sequencer, and muxes readback.
// Assumes: one channel owns the memory master port (no arbitration here).
module fifo_byte_dma
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              fifo_req,
    output logic              fifo_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_ext,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              start_evt,
    output logic              end_evt
);

    logic [ADDR_W-1:0] src_ptr;
    logic [ADDR_W-1:0] dst_ptr;
    logic [CNT_W-1:0]  byte_total;
    logic              ext_sel;
    logic              chan_en;
    logic              arm;
    logic              step;
    logic              finish;
    logic              done;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_sel     (reg_sel),
        .wr_data    (reg_wdata),
        .step       (step),
        .finish     (finish),
        .src_ptr    (src_ptr),
        .dst_ptr    (dst_ptr),
        .byte_total (byte_total),
        .ext_sel    (ext_sel),
        .chan_en    (chan_en),
        .arm        (arm),
        .start_evt  (start_evt)
    );

    dma_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (arm),
        .step  (step),
        .total (byte_total),
        .done  (done)
    );

    dma_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .done      (done),
        .fifo_req  (fifo_req),
        .ext_sel   (ext_sel),
        .src_ptr   (src_ptr),
        .dst_ptr   (dst_ptr),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_ext   (mem_ext),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fifo_ack  (fifo_ack),
        .step      (step),
        .finish    (finish),
        .end_evt   (end_evt)
    );

    // Readback mux over the four register selects.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_SRC: reg_rdata = REG_W'(src_ptr);
            SEL_DST: reg_rdata = REG_W'(dst_ptr);
            SEL_CNT: reg_rdata = REG_W'(byte_total);
            default: reg_rdata = REG_W'({ext_sel, chan_en});
        endcase
    end

    p_no_event_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> !end_evt);

endmodule

// File: tb/test_fifo_byte_dma.sv
// Bench: directed corner cases plus seeded random runs, checked against
// source patterns computed by bench functions.
module test_fifo_byte_dma;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int REG_W  = 16;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              fifo_req = 1'b0;
    logic              fifo_ack;
    logic              mem_req;
    logic              mem_we;
    logic              mem_ext;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              start_evt;
    logic              end_evt;

    fifo_byte_dma i_fifo_byte_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_req(fifo_req),
        .fifo_ack(fifo_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_ext(mem_ext), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .start_evt(start_evt), .end_evt(end_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int req_mode = 0;
    int n_start = 0, n_end = 0, n_ack = 0, n_mem = 0;
    int ext_err = 0, wide_err = 0;
    logic exp_ext = 1'b0;
    logic prev_start = 1'b0, prev_end = 1'b0;
    logic [7:0] dst_mem [256];

    // Source patterns for the two source spaces.
    function automatic logic [7:0] src_byte(input logic ext, input logic [7:0] a);
        return ext ? (a * 8'd3 + 8'd7) : (a ^ 8'h5A);
    endfunction

    // Memory model: one-cycle read latency, writes into the destination array.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= src_byte(mem_ext, mem_addr[7:0]);
        if (mem_req && mem_we)  dst_mem[mem_addr[7:0]] <= mem_wdata;
    end

    // FIFO request driver: off, steady, or random per cycle.
    always @(negedge clk) begin
        if (req_mode == 2) fifo_req <= 1'($urandom % 2);
        else               fifo_req <= (req_mode == 1);
    end

    // Monitor: event and access counts, pulse widths, source-space line.
    always @(negedge clk) begin
        if (rst_n) begin
            n_start += int'(start_evt);
            n_end   += int'(end_evt);
            n_ack   += int'(fifo_ack);
            n_mem   += int'(mem_req);
            if ((start_evt && prev_start) || (end_evt && prev_end)) wide_err++;
            if (mem_req && (mem_ext !== (exp_ext && !mem_we))) ext_err++;
            prev_start = start_evt;
            prev_end   = end_evt;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [REG_W-1:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [REG_W-1:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic clear_counts();
        n_start = 0; n_end = 0; n_ack = 0; n_mem = 0; ext_err = 0; wide_err = 0;
    endtask

    task automatic wait_idle();
        logic [REG_W-1:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_read(2'd3, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    // Program a run and raise enable; checks the start strobe timing (R9).
    task automatic arm_run(input int s, input int d, input int n, input logic ext);
        for (int i = 0; i < 256; i++) dst_mem[i] = 8'hEE;
        clear_counts();
        exp_ext = ext;
        reg_write(2'd0, REG_W'(s));
        reg_write(2'd1, REG_W'(d));
        reg_write(2'd2, REG_W'(n));
        reg_write(2'd3, {14'd0, ext, 1'b1});
        check("R9 start strobe after enabling write", 32'(start_evt), 32'd1);
    endtask

    // Wait for self-disable and check every outcome of the run.
    task automatic finish_run(input int s, input int d, input int n, input logic ext);
        logic [REG_W-1:0] v;
        int bad = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++)
            if (dst_mem[8'(d + i)] !== src_byte(ext, 8'(s + i))) bad++;
        check("R3 destination bytes", 32'(bad), 32'd0);
        check("R3 guard byte untouched", 32'(dst_mem[8'(d + n)]), 32'hEE);
        check("R3 one ack per byte", 32'(n_ack), 32'(n));
        check("R3 two accesses per byte", 32'(n_mem), 32'(2 * n));
        reg_read(2'd0, v); check("R4 source pointer advanced", 32'(v), 32'(16'(s + n)));
        reg_read(2'd1, v); check("R4 dest pointer advanced", 32'(v), 32'(16'(d + n)));
        reg_read(2'd2, v); check("R7 total kept", 32'(v), 32'(n));
        reg_read(2'd3, v); check("R7 enable self-cleared", 32'(v), {30'd0, ext, 1'b0});
        check("R7 one end event", 32'(n_end), 32'd1);
        check("R9 one start event", 32'(n_start), 32'd1);
        check("R9 single-cycle strobes", 32'(wide_err), 32'd0);
        check("R5 source-space line", 32'(ext_err), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [REG_W-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), v);
            check("R1 readback zero after reset", 32'(v), 32'd0);
        end
        check("R1 outputs idle", {28'd0, mem_req, fifo_ack, start_evt, end_evt}, 32'd0);

        // R2: request high while disabled, registers being programmed.
        clear_counts();
        req_mode = 1;
        reg_write(2'd0, 16'd5);
        reg_write(2'd2, 16'd4);
        repeat (30) @(negedge clk);
        check("R2 no access while disabled", 32'(n_mem), 32'd0);
        check("R2 no ack while disabled", 32'(n_ack), 32'd0);

        // R8: zero total ends at once with no traffic.
        req_mode = 1;
        arm_run(20, 40, 0, 1'b0);
        @(negedge clk);
        check("R8 end strobe one cycle after start", 32'(end_evt), 32'd1);
        finish_run(20, 40, 0, 1'b0);
        check("R8 no memory access", 32'(n_mem), 32'd0);

        // R6 and R3: enable while stalled, try to overwrite everything.
        req_mode = 0;
        arm_run(10, 100, 5, 1'b1);
        reg_write(2'd0, 16'd77);
        reg_write(2'd1, 16'd77);
        reg_write(2'd2, 16'd9);
        reg_write(2'd3, 16'd0);
        reg_read(2'd0, v); check("R6 source write ignored", 32'(v), 32'd10);
        reg_read(2'd1, v); check("R6 dest write ignored", 32'(v), 32'd100);
        reg_read(2'd2, v); check("R6 total write ignored", 32'(v), 32'd5);
        reg_read(2'd3, v); check("R6 control write ignored", 32'(v), 32'd3);
        repeat (20) @(negedge clk);
        check("R3 no byte without request", 32'(n_ack), 32'd0);
        req_mode = 1;
        finish_run(10, 100, 5, 1'b1);

        // R3/R4: single-byte run at the top of the address window.
        req_mode = 1;
        arm_run(255, 254, 1, 1'b0);
        finish_run(255, 254, 1, 1'b0);

        // Random runs with a toggling request line.
        for (int k = 0; k < 20; k++) begin
            int s = int'($urandom % 200);
            int d = int'($urandom % 200);
            int n = int'($urandom % 13);
            logic e = 1'($urandom % 2);
            req_mode = 2;
            arm_run(s, d, n, e);
            finish_run(s, d, n, e);
        end

        req_mode = 0;
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule